// File: doc/BRIEF.md
# Sync-Locking Serial Word Deserializer

This block takes a serial bit stream from a front-end readout chip, one bit per clock, and recovers 24-bit word boundaries on its own. It slides a 24-bit window over the incoming bits and looks for a fixed sync pattern at every bit offset. Once that pattern has repeated at a steady alignment, the block declares lock and starts cutting the stream into words.

While locked, every word that equals the sync pattern is dropped. Every other word goes out to the downstream event buffer as a data word with a single-cycle valid strobe. The block expects a sync word at a fixed spacing of frames. If too many of these expected sync words are missing in a row, it gives up the alignment and starts searching again.

The serial clock runs at the bit rate, about 140 MHz in the intended use. Clock recovery and the line receiver are outside this block.

Top module: `sync_deser`

## Requirements
- R1: After reset, `locked` and `ev_valid` are both low.
- R2: No event word is delivered unless the block was locked when the word completed. Junk words received before lock, and words received after lock is lost, produce no `ev_valid`.
- R3: Bits enter MSB first, so the first bit received becomes bit 23 of a word. While searching, the last 24 bits are compared against the sync pattern on every bit. The pattern is a parameter with default 24'hFFF000, and a match may occur at any bit offset.
- R4: Lock is declared after the sync pattern has been seen on 3 consecutive word boundaries at the same alignment. A word that is not sync during this confirmation returns the block to searching.
- R5: While locked, a word that exactly equals the sync pattern is discarded, in any frame slot. Every other word appears on `ev_word` with `ev_valid` high for one cycle, in arrival order.
- R6: While locked, an expected sync slot occurs every SYNC_EVERY words (default 4). The last confirming sync word is slot 0, so the 3 words after lock are data slots. A sync word in a data slot changes neither lock nor the miss count.
- R7: Lock is lost after 4 consecutive expected sync slots hold a non-sync word. A sync word in such a slot clears the miss count. The word that causes the loss is still delivered as an event, in the same edge on which `locked` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit, sampled on the rising edge |
| locked | output | 1 | High while word alignment is held |
| ev_valid | output | 1 | One-cycle strobe for `ev_word` |
| ev_word | output | 24 | Event word forwarded to the buffer |

## Verification
Two functions fall on the same edge when the fourth consecutive non-sync word arrives in an expected sync slot. That word must be delivered as an event, and lock must drop on that same edge. The bench provokes this by sending frames whose first word is replaced by data, with one frame in between carrying a real sync word to clear the count. It then judges three things: the missing word is the last entry in the event log, `locked` is low afterwards, and the filler words that follow the loss are not delivered.

// File: rtl/sync_deser.sv
`timescale 1ns/1ps
module sync_deser #(
  parameter int WORD_W      = 24,
  parameter logic [WORD_W-1:0] SYNC_PAT = 24'hFFF000,
  parameter int SYNC_EVERY  = 4,
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic              locked,
  output logic              ev_valid,
  output logic [WORD_W-1:0] ev_word
);
  localparam int BC_W = $clog2(WORD_W);
  localparam int WC_W = (SYNC_EVERY > 1) ? $clog2(SYNC_EVERY) : 1;
  localparam int HC_W = $clog2(LOCK_HITS + 1);
  localparam int MC_W = $clog2(LOSS_MISSES + 1);

  typedef enum logic [1:0] {HUNT, CONFIRM, ALIGNED} st_t;

  st_t              st;
  logic [WORD_W-1:0] sreg;
  logic [BC_W-1:0]  bcnt;
  logic [WC_W-1:0]  wcnt;
  logic [HC_W-1:0]  hits;
  logic [MC_W-1:0]  misses;

  wire hit      = (sreg == SYNC_PAT);
  wire word_rdy = (bcnt == '0);
  assign locked = (st == ALIGNED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= HUNT;
      sreg     <= '0;
      bcnt     <= '0;
      wcnt     <= '0;
      hits     <= '0;
      misses   <= '0;
      ev_valid <= 1'b0;
      ev_word  <= '0;
    end else begin
      sreg     <= {sreg[WORD_W-2:0], ser_in};
      ev_valid <= 1'b0;
      bcnt     <= (bcnt == BC_W'(WORD_W-1)) ? '0 : bcnt + 1'b1;
      case (st)
        HUNT: if (hit) begin
          st   <= CONFIRM;
          bcnt <= BC_W'(1);
          hits <= HC_W'(1);
        end
        CONFIRM: if (word_rdy) begin
          if (!hit) st <= HUNT;
          else if (hits == HC_W'(LOCK_HITS-1)) begin
            st     <= ALIGNED;
            wcnt   <= WC_W'(1 % SYNC_EVERY);
            misses <= '0;
          end else hits <= hits + 1'b1;
        end
        ALIGNED: if (word_rdy) begin
          wcnt <= (wcnt == WC_W'(SYNC_EVERY-1)) ? '0 : wcnt + 1'b1;
          if (!hit) begin
            ev_valid <= 1'b1;
            ev_word  <= sreg;
          end
          if (wcnt == '0) begin
            if (hit) misses <= '0;
            else if (misses == MC_W'(LOSS_MISSES-1)) st <= HUNT;
            else misses <= misses + 1'b1;
          end
        end
        default: st <= HUNT;
      endcase
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);
  a_r2_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(locked));
  a_r5_sync_never_out: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_word != SYNC_PAT));
  a_r4_lock_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit));
  a_r7_loss_emits_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (ev_valid && !$past(hit)));
endmodule

// File: tb/test_sync_deser.sv
`timescale 1ns/1ps
module test_sync_deser;
  localparam logic [23:0] SYNC = 24'hFFF000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic locked, ev_valid;
  logic [23:0] ev_word;

  int n_chk = 0;
  int n_fail = 0;
  int ev_n = 0;
  logic [23:0] ev_log [0:63];

  always #2 clk = ~clk;

  sync_deser i_sync_deser (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .locked(locked), .ev_valid(ev_valid), .ev_word(ev_word)
  );

  always @(negedge clk)
    if (rst_n && ev_valid) begin
      if (ev_n < 64) ev_log[ev_n] = ev_word;
      ev_n++;
    end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_in = b;
    #1;
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic t_reset;
    check("R1 locked", locked, 0);
    check("R1 ev_valid", ev_valid, 0);
  endtask

  task automatic t_no_lock;
    send_word(24'h0F0F0F);
    send_word(24'h123456);
    send_word(24'h0F0F0F);
    check("R2 no events before lock", ev_n, 0);
    check("R2 unlocked on junk", locked, 0);
  endtask

  task automatic t_lock;
    int base;
    base = ev_n;
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    send_word(SYNC);
    send_word(SYNC);
    check("R4 two syncs not enough", locked, 0);
    send_word(SYNC);
    send_word(24'hA5C3E1);
    check("R3 R4 locked at offset", locked, 1);
    send_word(24'h000001);
    send_word(24'h123456);
    send_word(SYNC);
    send_word(24'hFFFFFF);
    send_word(24'h000000);
    send_word(24'h800000);
    send_word(SYNC);
    check("R5 event count", ev_n - base, 6);
    check("R5 word 1", ev_log[base],   24'hA5C3E1);
    check("R5 word 3", ev_log[base+2], 24'h123456);
    check("R5 word 4", ev_log[base+3], 24'hFFFFFF);
    check("R5 word 6", ev_log[base+5], 24'h800000);
  endtask

  task automatic t_stray_sync;
    int base;
    base = ev_n;
    send_word(SYNC);
    send_word(24'h111111);
    send_word(24'h222222);
    send_word(SYNC);
    send_word(24'h333333);
    send_word(24'h444444);
    send_word(24'h555555);
    send_word(SYNC);
    check("R6 stray sync dropped count", ev_n - base, 5);
    check("R6 first after stray", ev_log[base], 24'h111111);
    check("R6 last", ev_log[base+4], 24'h555555);
    check("R6 still locked", locked, 1);
  endtask

  task automatic t_loss;
    int base;
    base = ev_n;
    for (int i = 1; i <= 3; i++) send_word(24'h3C3C00 + 24'(i));
    for (int f = 1; f <= 8; f++) begin
      send_word((f == 4) ? SYNC : 24'h0A0000 + 24'(f));
      if (f == 8) check("R7 lock held before fourth miss event", ev_n - base, 30);
      for (int i = 1; i <= 3; i++) send_word(24'h3C3C00 + 24'(i));
      if (f == 7) check("R7 three misses keep lock", locked, 1);
    end
    check("R7 lock lost", locked, 0);
    check("R7 event count incl. losing word", ev_n - base, 31);
    check("R7 losing word delivered", ev_log[ev_n-1], 24'h0A0008);
    check("R7 word before loss", ev_log[ev_n-2], 24'h3C3C03);
  endtask

  task automatic t_relock;
    int base;
    base = ev_n;
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    send_word(SYNC);
    send_word(SYNC);
    send_word(24'h00AA00);
    send_word(SYNC);
    send_word(SYNC);
    check("R4 broken confirm no lock", locked, 0);
    check("R2 no events while hunting", ev_n - base, 0);
    send_word(SYNC);
    send_word(24'h0C0C0C);
    check("R4 relocked", locked, 1);
    send_word(24'h0D0D0D);
    send_word(24'h0E0E0E);
    send_word(SYNC);
    check("R5 relock event count", ev_n - base, 3);
    check("R5 relock first word", ev_log[base], 24'h0C0C0C);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_no_lock;
    t_lock;
    t_stray_sync;
    t_loss;
    t_relock;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule